// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a clocked host to an asynchronous 64K x 8 static RAM. The host sets a one-bit request together with a 16-bit address, a write flag and, for writes, a byte of data. The controller then runs one complete memory access. It drives the address, an active-low chip select, an active-high chip select, an active-low output enable and an active-low write enable. It also controls the direction of the bidirectional data bus. When the access is finished it raises `ready` for one clock. After a read, the byte taken from the memory is shown on `rdata` in that same cycle.

The memory has no clock, so every timing limit is met by holding a phase for a whole number of clock cycles. Each phase length is the nanosecond limit divided by `CLK_PERIOD_NS`, rounded up. `SPEED_GRADE_NS` selects one of two sets of limits:
- 85 ns grade: 85 ns cycle, 60 ns write pulse, 70 ns for address-valid and chip-select to end of write, 35 ns data setup.
- 100 ns grade: 100 ns cycle, 70 ns write pulse, 80 ns for address-valid and chip-select to end of write, 40 ns data setup.

The controller has five states:
- `ST_IDLE`: the memory is in standby and a request is taken. A read request moves to `ST_READ`. A write request moves to `ST_TURN` if the previous access was a read, and to `ST_WRITE` otherwise.
- `ST_TURN`: bus turnaround. When its count runs out the controller moves to `ST_WRITE`.
- `ST_READ`: when its count runs out the controller moves to `ST_DONE`.
- `ST_WRITE`: when its count runs out the controller moves to `ST_DONE`.
- `ST_DONE`: always returns to `ST_IDLE` on the next clock.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, and in every idle cycle, the memory pins are in standby: `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, and `ready`=0.
- R2: A read request taken in idle drives the request address on `mem_addr` and holds `mem_cs1_n`=0, `mem_cs2`=1, `mem_oe_n`=0, `mem_we_n`=1. This lasts for exactly ceil(tRC/T) cycles, which is 17 at the defaults (85 ns grade, 5 ns clock).
- R3: The byte on `mem_dq` is registered at the clock edge that ends the read phase. It appears on `rdata` in the cycle where `ready` is 1.
- R4: A write holds `mem_we_n`=0, `mem_cs1_n`=0, `mem_cs2`=1 and `mem_oe_n`=1, with the address stable and the write byte driven on `mem_dq`. This lasts for ceil(max(write cycle, write pulse, address-valid, chip-select, data setup)/T) cycles, which is 17 at the defaults.
- R5: The controller drives `mem_dq` only while `mem_we_n` is 0, and `mem_oe_n` is never 0 while `mem_we_n` is 0.
- R6: A write that follows a read waits ceil(20 ns/T) standby cycles (4 at the defaults) between idle and the fall of `mem_we_n`. A write that follows a write, or that follows reset, starts directly from idle.
- R7: `ready` is 1 for exactly one cycle, the cycle right after the access phase ends. During that cycle the memory pins are in standby. The controller is idle in the next cycle.
- R8: A request is taken only in idle. A request raised while an access or turnaround is in progress is dropped: it starts no access and changes no memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, sampled only in idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte from the last read |
| mem_addr | output | 16 | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq | inout | 8 | Bidirectional memory data bus |

## Verification
The bench runs several access patterns:
- Writes after reset and back-to-back writes. These show that no turnaround is inserted when the bus direction does not change.
- Reads that follow writes. These check both the read phase length and the data captured.
- A write right after a read. This must show the extra standby gap, which tells the two turnaround cases apart.
- Accesses to addresses 0x0000 and 0xFFFF. These expose any fault in the address path.
- A request raised in the middle of a read. This must leave no trace in the pin activity, or in the memory contents that a later read brings back.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } state_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Grade-dependent limits in ns; any grade other than 100 uses the fast set.
    function automatic int cycle_ns(input int grade);
        return (grade == 100) ? 100 : 85;
    endfunction

    function automatic int wpulse_ns(input int grade);
        return (grade == 100) ? 70 : 60;
    endfunction

    function automatic int sel_to_end_ns(input int grade);
        return (grade == 100) ? 80 : 70;
    endfunction

    function automatic int dsetup_ns(input int grade);
        return (grade == 100) ? 40 : 35;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/sram_ctl_dq_pad.sv
module sram_ctl_dq_pad #(
    parameter int DATA_W = 8
) (
    input  logic              drive,
    input  logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] din,
    inout  wire  [DATA_W-1:0] pad
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign pad[b] = drive ? dout[b] : 1'bz;
        assign din[b] = pad[b];
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 5,
    parameter int SPEED_GRADE_NS = 85,
    parameter int BUS_TURN_NS    = 20,
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int RD_CYC  = ceil_div(cycle_ns(SPEED_GRADE_NS), CLK_PERIOD_NS);
    localparam int WR_NS   = max2(max2(cycle_ns(SPEED_GRADE_NS), wpulse_ns(SPEED_GRADE_NS)),
                                  max2(sel_to_end_ns(SPEED_GRADE_NS), dsetup_ns(SPEED_GRADE_NS)));
    localparam int WR_CYC  = ceil_div(WR_NS, CLK_PERIOD_NS);
    localparam int TA_RAW  = ceil_div(BUS_TURN_NS, CLK_PERIOD_NS);
    localparam int TA_CYC  = (TA_RAW < 1) ? 1 : TA_RAW;
    localparam int MAX_CYC = max2(max2(RD_CYC, WR_CYC), TA_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    state_t            state, state_nx;
    logic              phase_done;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              accept;
    logic              op_wr;
    logic              prev_was_rd;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] dq_in;
    logic              dq_drive;

    assign accept = (state == ST_IDLE) && req;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (!req_wr)          state_nx = ST_READ;
                    else if (prev_was_rd) state_nx = ST_TURN;
                    else                  state_nx = ST_WRITE;
                end
            end
            ST_TURN:  if (phase_done) state_nx = ST_WRITE;
            ST_READ:  if (phase_done) state_nx = ST_DONE;
            ST_WRITE: if (phase_done) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // phase length selection on entry to a timed state
    always_comb begin
        timer_load = (state_nx != state);
        unique case (state_nx)
            ST_TURN:  timer_val = CNT_W'(TA_CYC - 1);
            ST_READ:  timer_val = CNT_W'(RD_CYC - 1);
            ST_WRITE: timer_val = CNT_W'(WR_CYC - 1);
            default:  timer_val = '0;
        endcase
    end

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (phase_done)
    );

    // request capture, direction history and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            op_wr       <= 1'b0;
            prev_was_rd <= 1'b0;
            rdata       <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                op_wr   <= req_wr;
            end
            if (state == ST_READ && phase_done) begin
                rdata       <= dq_in;
                prev_was_rd <= 1'b1;
            end
            if (state == ST_WRITE && phase_done) begin
                prev_was_rd <= 1'b0;
            end
        end
    end

    // pin outputs decoded from the state register
    always_comb begin
        mem_cs1_n = 1'b1;
        mem_cs2   = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        dq_drive  = 1'b0;
        ready     = 1'b0;
        unique case (state)
            ST_READ: begin
                mem_cs1_n = 1'b0;
                mem_cs2   = 1'b1;
                mem_oe_n  = 1'b0;
            end
            ST_WRITE: begin
                mem_cs1_n = 1'b0;
                mem_cs2   = 1'b1;
                mem_we_n  = 1'b0;
                dq_drive  = op_wr;
            end
            ST_DONE: ready = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr = addr_q;

    sram_ctl_dq_pad #(.DATA_W(DATA_W)) u_pad (
        .drive (dq_drive),
        .dout  (wdata_q),
        .din   (dq_in),
        .pad   (mem_dq)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 16,
    parameter int WR_CYC = 17,
    parameter int TA_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_oe_n,
    input logic              mem_we_n
);

    logic [15:0] we_low_cycles;
    logic [15:0] oe_high_cycles;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cycles  <= '0;
            oe_high_cycles <= 16'hFFFF;
        end else begin
            if (!mem_we_n) we_low_cycles <= (we_low_cycles == 16'hFFFF) ? we_low_cycles : we_low_cycles + 1'b1;
            else           we_low_cycles <= '0;
            if (mem_oe_n)  oe_high_cycles <= (oe_high_cycles == 16'hFFFF) ? oe_high_cycles : oe_high_cycles + 1'b1;
            else           oe_high_cycles <= '0;
        end
    end

    AST_WE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2)); // R4

    AST_ADDR_HELD_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R4

    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cycles >= 16'(WR_CYC))); // R4

    AST_NO_OE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R5

    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (oe_high_cycles >= 16'(TA_CYC))); // R6

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R7

    AST_READY_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n)); // R7

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W (ADDR_W),
    .WR_CYC (WR_CYC),
    .TA_CYC (TA_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

    // Phase lengths at 5 ns clock, 85 ns grade, from the requirements.
    localparam int RD_LEN = 17;
    localparam int WR_LEN = 17;
    localparam int TA_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic [15:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n;
    wire  [7:0]  mem_dq;

    always #2.5 clk = ~clk;

    sram_ctl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .rdata     (rdata),
        .mem_addr  (mem_addr),
        .mem_cs1_n (mem_cs1_n),
        .mem_cs2   (mem_cs2),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq    (mem_dq)
    );

    // Behavioural memory
    logic [7:0] mem [int];
    logic       mem_drv;
    logic [7:0] mem_out;

    always @* begin
        mem_drv = !mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n;
        mem_out = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    end
    assign mem_dq = mem_drv ? mem_out : 8'bz;

    always @(negedge clk) begin
        if (!mem_cs1_n && mem_cs2 && !mem_we_n) mem[int'(mem_addr)] = mem_dq;
    end

    int checks = 0;
    int fails  = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: 0 idle, 1 turn, 2 read, 3 write, 4 done
    int          ph = 0;
    int          left = 0;
    bit          last_rd = 0;
    bit          m_wr = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd = '0;
    logic [7:0]  exp_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            last_rd = 0;
        end else begin
            case (ph)
                0: if (req) begin
                    m_wr = req_wr; m_addr = req_addr; m_wd = req_wdata;
                    if (!req_wr) begin ph = 2; left = RD_LEN; end
                    else if (last_rd) begin ph = 1; left = TA_LEN; end
                    else begin ph = 3; left = WR_LEN; end
                end
                1: begin left--; if (left == 0) begin ph = 3; left = WR_LEN; end end
                2: begin
                    left--;
                    if (left == 0) begin
                        ph = 4; last_rd = 1;
                        exp_rd = mem.exists(int'(m_addr)) ? mem[int'(m_addr)] : 8'h00;
                    end
                end
                3: begin left--; if (left == 0) begin ph = 4; last_rd = 0; end end
                default: ph = 0;
            endcase
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            case (ph)
                2: begin
                    check("R2", "read pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b0101);
                    check("R2", "read addr", mem_addr, m_addr);
                end
                3: begin
                    check("R4", "write pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b0110);
                    check("R4", "write addr", mem_addr, m_addr);
                    check("R4", "write data", mem_dq, m_wd);
                end
                1: check("R6", "turnaround pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b1011);
                4: begin
                    check("R7", "done pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b1011);
                    if (!m_wr) check("R3", "rdata", rdata, exp_rd);
                end
                default: check("R1", "idle pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b1011);
            endcase
            check("R7", "ready", ready, (ph == 4) ? 1 : 0);
            if (!mem_we_n) check("R5", "oe high during write", mem_oe_n, 1);
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
    endtask

    // Counts the cycles between acceptance and the fall of WE.
    task automatic write_gap(input logic [15:0] a, input logic [7:0] d, input int exp_gap, input string tag);
        int n = 0;
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        while (mem_we_n && n < 50) begin n++; @(negedge clk); end
        check(tag, "cycles before WE low", n, exp_gap);
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b1011);
        check("R1", "reset ready", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        write_gap(16'h1234, 8'hA5, 0, "R6");       // from reset: no gap
        write_gap(16'h0000, 8'h3C, 0, "R6");       // write after write: no gap
        access(1'b1, 16'hFFFF, 8'hC3);
        access(1'b0, 16'h1234, 8'h00);
        check("R3", "rdata after 1234", rdata, 8'hA5);
        write_gap(16'h1234, 8'h5A, TA_LEN, "R6");  // write after read
        access(1'b0, 16'h1234, 8'h00);
        check("R3", "rewritten byte", rdata, 8'h5A);
        access(1'b0, 16'hFFFF, 8'h00);
        check("R3", "top address", rdata, 8'hC3);

        // R8: request raised mid-read is dropped
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_addr = 16'h0000;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 16'h0000; req_wdata = 8'hFF;
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        check("R8", "read during busy", rdata, 8'h3C);
        repeat (4) @(negedge clk);
        check("R8", "no access after busy request", {mem_cs1_n, mem_cs2}, 2'b10);
        access(1'b0, 16'h0000, 8'h00);
        check("R8", "memory unchanged", rdata, 8'h3C);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule